// File: doc/BRIEF.md
# Rotate, Shift and Bit-Manipulation Unit

This is a purely combinational datapath slice for the bit-manipulation group of a small 8-bit processor. The decoder supplies a data byte, the current carry flag, a bit index, an operation code and one qualifier bit. The unit returns three things: the new byte with a write-enable, the next zero, subtract, half-carry and carry flags, and a four-bit mask that marks which of those flags the core should commit.

The unit covers several kinds of operation. Rotates can be circular or pass through the carry. There is a left shift that fills with zero, a right shift that keeps the sign bit, and a right shift that fills with zero. The remaining operations are a nibble exchange, a single-bit test, a single-bit clear and a single-bit set. The qualifier bit marks the short accumulator-only encodings of the four rotates, which always clear the zero flag. Fetching the operand and sequencing a read-modify-write through memory are left to the surrounding core.

Top module: `rsb_unit`

## Requirements
- R1: Operation codes: 0 circular left, 1 circular right, 2 left through carry, 3 right through carry, 4 left shift, 5 arithmetic right shift, 6 logical right shift, 7 nibble exchange, 8 bit test, 9 bit clear, 10 bit set. Flag mask bits are Z=3, N=2, H=1, C=0. Through-carry left gives {d[6:0],cin} and carry d[7]. Through-carry right gives {cin,d[7:1]} and carry d[0].
- R2: Circular left gives {d[6:0],d[7]} and circular right gives {d[0],d[7:1]}. In both cases the bit moved around the end is also the new carry.
- R3: Left shift gives {d[6:0],0} and carry d[7]. Arithmetic right gives {d[7],d[7:1]} and logical right gives {0,d[7:1]}. Both right shifts take d[0] as the carry.
- R4: Codes 0 to 6 write the result and update all four flags. N and H become 0 and Z is 1 exactly when the result is zero, unless R5 applies.
- R5: With the accumulator-form input high, codes 0 to 3 give Z=0 whatever the result. On codes 4 to 10 that input has no effect.
- R6: Nibble exchange gives {d[3:0],d[7:4]}, writes the result, updates all four flags, sets Z when the result is zero and clears N, H and C.
- R7: Bit test writes no result (write-enable 0) and gives mask 1110. It sets Z when bit d[idx] is 0, clears N and sets H. The carry output equals the carry input.
- R8: Bit clear and bit set write a byte that differs from d only in bit idx (index 0 is the least significant bit), which becomes 0 or 1 respectively. The flag mask is 0000.
- R9: Codes 11 to 15 give write-enable 0, mask 0000 and a result equal to d.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 8 | Operand byte d |
| cin_i | input | 1 | Current carry flag |
| bidx_i | input | 3 | Bit index for test, clear and set |
| op_i | input | 4 | Operation code |
| acc_form_i | input | 1 | Short accumulator-rotate qualifier |
| res_o | output | 8 | Result byte |
| res_we_o | output | 1 | Result write-enable |
| z_o | output | 1 | Next zero flag |
| n_o | output | 1 | Next subtract flag |
| h_o | output | 1 | Next half-carry flag |
| c_o | output | 1 | Next carry flag |
| fmask_o | output | 4 | Flag update mask {Z,N,H,C} |

## Verification
For each operation code, the operand is swept over all 256 byte values with both carry states, and every bit index is applied on the bit-addressed codes. This sweep separates the fill sources of the rotates and shifts (old carry, wrapped bit, sign bit, zero), because they differ only when the end bits and the carry disagree. Directed corner values are added: 0x80 and 0x01 with carry clear, which rotate or shift to zero, and 0x00. These tell the forced-zero accumulator form apart from the general form. Sweeps with the qualifier high on the non-rotate codes show that it has no effect there.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

   typedef enum logic [3:0] {
      OP_RLC  = 4'd0,
      OP_RRC  = 4'd1,
      OP_RL   = 4'd2,
      OP_RR   = 4'd3,
      OP_SLA  = 4'd4,
      OP_SRA  = 4'd5,
      OP_SRL  = 4'd6,
      OP_SWAP = 4'd7,
      OP_BTST = 4'd8,
      OP_BCLR = 4'd9,
      OP_BSET = 4'd10
   } rsb_op_e;

   localparam int unsigned FM_Z = 3;
   localparam int unsigned FM_N = 2;
   localparam int unsigned FM_H = 1;
   localparam int unsigned FM_C = 0;

   function automatic logic is_rotate(input rsb_op_e op);
      return (op == OP_RLC) || (op == OP_RRC) || (op == OP_RL) || (op == OP_RR);
   endfunction

   function automatic logic is_shift_class(input rsb_op_e op);
      return is_rotate(op) || (op == OP_SLA) || (op == OP_SRA) || (op == OP_SRL);
   endfunction

endpackage

// File: rtl/rsb_shift.sv
module rsb_shift
   import rsb_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic [DATA_W-1:0] opnd_i,
   input  logic              cin_i,
   input  rsb_op_e           op_i,
   output logic [DATA_W-1:0] res_o,
   output logic              cout_o
);
   localparam int unsigned MSB = DATA_W - 1;

   logic go_left;
   logic fill_lo;
   logic fill_hi;

   always_comb begin
      go_left = (op_i == OP_RLC) || (op_i == OP_RL) || (op_i == OP_SLA);
      unique case (op_i)
         OP_RLC:  fill_lo = opnd_i[MSB];
         OP_RL:   fill_lo = cin_i;
         default: fill_lo = 1'b0;
      endcase
      unique case (op_i)
         OP_RRC:  fill_hi = opnd_i[0];
         OP_RR:   fill_hi = cin_i;
         OP_SRA:  fill_hi = opnd_i[MSB];
         default: fill_hi = 1'b0;
      endcase
      cout_o = go_left ? opnd_i[MSB] : opnd_i[0];
   end

   for (genvar i = 0; i < DATA_W; i++) begin : g_lane
      if (i == 0) begin : g_lo
         assign res_o[i] = go_left ? fill_lo : opnd_i[i+1];
      end else if (i == MSB) begin : g_hi
         assign res_o[i] = go_left ? opnd_i[i-1] : fill_hi;
      end else begin : g_mid
         assign res_o[i] = go_left ? opnd_i[i-1] : opnd_i[i+1];
      end
   end

   always_comb begin
      if (is_shift_class(op_i)) begin
         p_one_lane_move_r3: assert ($countones(res_o) <= $countones(opnd_i) + 1)
            else $error("shift lane count grew by more than one");
      end
   end

endmodule

// File: rtl/rsb_bitop.sv
module rsb_bitop
   import rsb_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   localparam int unsigned IDX_W = $clog2(DATA_W),
   localparam int unsigned HALF  = DATA_W / 2
) (
   input  logic [DATA_W-1:0] opnd_i,
   input  logic [IDX_W-1:0]  bidx_i,
   output logic [DATA_W-1:0] swap_o,
   output logic [DATA_W-1:0] clr_o,
   output logic [DATA_W-1:0] set_o,
   output logic              bit_o
);
   logic [DATA_W-1:0] sel;

   for (genvar i = 0; i < DATA_W; i++) begin : g_sel
      assign sel[i] = (bidx_i == IDX_W'(i));
   end

   assign swap_o = {opnd_i[HALF-1:0], opnd_i[DATA_W-1:HALF]};
   assign clr_o  = opnd_i & ~sel;
   assign set_o  = opnd_i | sel;
   assign bit_o  = |(opnd_i & sel);

   always_comb begin
      p_sel_onehot_r8: assert ($onehot0(clr_o ^ set_o))
         else $error("bit select not one-hot");
      p_swap_weight_r6: assert ($countones(swap_o) == $countones(opnd_i))
         else $error("swap changed bit weight");
   end

endmodule

// File: rtl/rsb_unit.sv
module rsb_unit
   import rsb_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   localparam int unsigned IDX_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] opnd_i,
   input  logic              cin_i,
   input  logic [IDX_W-1:0]  bidx_i,
   input  logic [3:0]        op_i,
   input  logic              acc_form_i,
   output logic [DATA_W-1:0] res_o,
   output logic              res_we_o,
   output logic              z_o,
   output logic              n_o,
   output logic              h_o,
   output logic              c_o,
   output logic [3:0]        fmask_o
);
   if ((DATA_W < 2) || (DATA_W % 2 != 0)) begin : g_bad_width
      $error("rsb_unit: DATA_W must be even and at least 2");
   end

   rsb_op_e           op;
   logic [DATA_W-1:0] sh_res;
   logic              sh_cout;
   logic [DATA_W-1:0] sw_res;
   logic [DATA_W-1:0] clr_res;
   logic [DATA_W-1:0] set_res;
   logic              sel_bit;

   assign op = rsb_op_e'(op_i);

   rsb_shift #(.DATA_W(DATA_W)) u_shift (
      .opnd_i (opnd_i),
      .cin_i  (cin_i),
      .op_i   (op),
      .res_o  (sh_res),
      .cout_o (sh_cout)
   );

   rsb_bitop #(.DATA_W(DATA_W)) u_bitop (
      .opnd_i (opnd_i),
      .bidx_i (bidx_i),
      .swap_o (sw_res),
      .clr_o  (clr_res),
      .set_o  (set_res),
      .bit_o  (sel_bit)
   );

   always_comb begin
      res_o    = opnd_i;
      res_we_o = 1'b0;
      z_o      = 1'b0;
      n_o      = 1'b0;
      h_o      = 1'b0;
      c_o      = cin_i;
      fmask_o  = 4'b0000;
      if (is_shift_class(op)) begin
         res_o    = sh_res;
         res_we_o = 1'b1;
         z_o      = (acc_form_i && is_rotate(op)) ? 1'b0 : (sh_res == '0);
         c_o      = sh_cout;
         fmask_o  = 4'b1111;
      end else begin
         unique case (op)
            OP_SWAP: begin
               res_o    = sw_res;
               res_we_o = 1'b1;
               z_o      = (sw_res == '0);
               c_o      = 1'b0;
               fmask_o  = 4'b1111;
            end
            OP_BTST: begin
               z_o      = ~sel_bit;
               h_o      = 1'b1;
               fmask_o  = 4'b1110;
            end
            OP_BCLR: begin
               res_o    = clr_res;
               res_we_o = 1'b1;
            end
            OP_BSET: begin
               res_o    = set_res;
               res_we_o = 1'b1;
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      if (!res_we_o) begin
         p_hold_when_no_write_r9: assert (res_o == opnd_i)
            else $error("result moved without write-enable");
      end
      if (op == OP_BTST) begin
         p_test_keeps_carry_r7: assert (!fmask_o[FM_C] && (c_o == cin_i))
            else $error("bit test touched carry");
      end
      if ((op == OP_BCLR) || (op == OP_BSET)) begin
         p_single_bit_r8: assert ($onehot0(res_o ^ opnd_i) && (fmask_o == 4'b0000))
            else $error("bit write altered more than one bit or flags");
      end
      if ((op == OP_RLC) || (op == OP_RRC)) begin
         p_circ_weight_r2: assert ($countones(res_o) == $countones(opnd_i))
            else $error("circular rotate lost a bit");
      end
      if (acc_form_i && is_rotate(op)) begin
         p_acc_zero_clear_r5: assert (!z_o && fmask_o[FM_Z])
            else $error("accumulator rotate left Z set");
      end
      if (is_shift_class(op)) begin
         p_nh_clear_r4: assert (!n_o && !h_o && (fmask_o == 4'b1111))
            else $error("shift flags wrong");
      end
   end

endmodule

// File: tb/rsb_unit_tb.sv
module rsb_unit_tb_top;

   logic       clk = 1'b0;
   logic [7:0] opnd;
   logic       cin;
   logic [2:0] bidx;
   logic [3:0] op;
   logic       acc;
   logic [7:0] res;
   logic       we, z, n, h, c;
   logic [3:0] fmask;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   rsb_unit dut_i (
      .opnd_i(opnd), .cin_i(cin), .bidx_i(bidx), .op_i(op), .acc_form_i(acc),
      .res_o(res), .res_we_o(we), .z_o(z), .n_o(n), .h_o(h), .c_o(c), .fmask_o(fmask)
   );

   // expected {res, we, z, n, h, c, mask} built from the requirement text
   function automatic logic [16:0] model(input logic [3:0] o, input logic [7:0] d,
                                         input logic ci, input logic [2:0] k, input logic af);
      logic [7:0] r; logic w; logic fz, fn, fh, fc; logic [3:0] m;
      r = d; w = 0; fz = 0; fn = 0; fh = 0; fc = ci; m = 4'b0000;
      case (o)
         4'd0: begin r = {d[6:0], d[7]}; fc = d[7]; end
         4'd1: begin r = {d[0], d[7:1]}; fc = d[0]; end
         4'd2: begin r = {d[6:0], ci};   fc = d[7]; end
         4'd3: begin r = {ci, d[7:1]};   fc = d[0]; end
         4'd4: begin r = {d[6:0], 1'b0}; fc = d[7]; end
         4'd5: begin r = {d[7], d[7:1]}; fc = d[0]; end
         4'd6: begin r = {1'b0, d[7:1]}; fc = d[0]; end
         4'd7: begin r = {d[3:0], d[7:4]}; fc = 0; end
         4'd8: begin fz = (d[k] == 1'b0); fh = 1; m = 4'b1110; end
         4'd9: begin r = d; r[k] = 1'b0; w = 1; end
         4'd10: begin r = d; r[k] = 1'b1; w = 1; end
         default: ;
      endcase
      if (o <= 4'd7) begin
         w = 1; m = 4'b1111;
         fz = (r == 8'h00) && !(af && o <= 4'd3);
      end
      return {r, w, fz, fn, fh, fc, m};
   endfunction

   task automatic apply_check(input logic [3:0] o, input logic [7:0] d, input logic ci,
                              input logic [2:0] k, input logic af, input string req);
      logic [16:0] exp_v, got;
      opnd = d; cin = ci; bidx = k; op = o; acc = af;
      #1;
      exp_v = model(o, d, ci, k, af);
      got = {res, we, z, n, h, c, fmask};
      checks++;
      if (got !== exp_v) begin
         errors++;
         $display("FAIL %s op=%0d d=%02h cin=%0b idx=%0d acc=%0b actual=%05h expected=%05h",
                  req, o, d, ci, k, af, got, exp_v);
      end
   endtask

   task automatic sweep(input logic [3:0] o, input logic af, input bit all_idx, input string req);
      for (int d = 0; d < 256; d++)
         for (int ci = 0; ci < 2; ci++)
            for (int k = 0; k < (all_idx ? 8 : 1); k++)
               apply_check(o, 8'(d), 1'(ci), 3'(k), af, req);
   endtask

   task automatic t_idle();            // R9: unassigned codes, also initial state
      apply_check(4'd15, 8'h00, 1'b0, 3'd0, 1'b0, "R9");
      for (int o = 11; o < 16; o++) sweep(4'(o), 1'b0, 0, "R9");
   endtask

   task automatic t_carry_rot();       // R1 R4 R5
      sweep(4'd2, 1'b0, 0, "R1");
      sweep(4'd3, 1'b0, 0, "R1");
      sweep(4'd2, 1'b1, 0, "R5");
      sweep(4'd3, 1'b1, 0, "R5");
   endtask

   task automatic t_circ_rot();        // R2 R5
      sweep(4'd0, 1'b0, 0, "R2");
      sweep(4'd1, 1'b0, 0, "R2");
      sweep(4'd0, 1'b1, 0, "R5");
      sweep(4'd1, 1'b1, 0, "R5");
   endtask

   task automatic t_shifts();          // R3 R4, qualifier ignored per R5
      for (int o = 4; o < 7; o++) begin
         sweep(4'(o), 1'b0, 0, "R3");
         sweep(4'(o), 1'b1, 0, "R5");
      end
   endtask

   task automatic t_swap();            // R6
      sweep(4'd7, 1'b0, 0, "R6");
      sweep(4'd7, 1'b1, 0, "R5");
   endtask

   task automatic t_btst();            // R7
      sweep(4'd8, 1'b0, 1, "R7");
      sweep(4'd8, 1'b1, 1, "R5");
   endtask

   task automatic t_bitwrite();        // R8
      sweep(4'd9, 1'b0, 1, "R8");
      sweep(4'd10, 1'b0, 1, "R8");
      sweep(4'd10, 1'b1, 1, "R5");
   endtask

   task automatic t_corners();         // R4 R5 zero-result edges
      apply_check(4'd2, 8'h80, 1'b0, 3'd0, 1'b0, "R4");
      apply_check(4'd2, 8'h80, 1'b0, 3'd0, 1'b1, "R5");
      apply_check(4'd3, 8'h01, 1'b0, 3'd0, 1'b1, "R5");
      apply_check(4'd4, 8'h80, 1'b0, 3'd0, 1'b1, "R5");
      apply_check(4'd6, 8'h01, 1'b1, 3'd0, 1'b0, "R3");
      apply_check(4'd0, 8'h00, 1'b1, 3'd0, 1'b1, "R5");
   endtask

   initial begin
      t_idle();
      t_carry_rot();
      t_circ_rot();
      t_shifts();
      t_swap();
      t_btst();
      t_bitwrite();
      t_corners();
      done = 1;
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 190000 && !done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=completion");
         done = 1;
      end
   end

   initial begin
      wait (done);
      #5;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule